// File: doc/BRIEF.md
# Four-Bit Function-Select ALU Slice

This block is a purely combinational arithmetic/logic slice that works on two 4-bit operands. A 4-bit select code and a mode bit together pick one of 32 operations. With the mode bit high, the slice applies one of the 16 possible two-input Boolean functions to each bit position separately. With the mode bit low, it applies one of 16 arithmetic functions built from a sum of two derived terms. A low-true carry input adds one to any arithmetic result. The same select code therefore names two unrelated operations, and the mode bit decides which one is performed.

Besides the 4-bit result, the slice drives four other outputs. The first is a low-true ripple carry out; in a subtraction it reads as "no borrow". The second and third are low-true group propagate and generate terms that do not depend on the carry input, so an external lookahead unit can use them. The fourth is an equality flag that is high when every result bit is 1. Wider words are built by feeding each slice's carry out into the carry input of the next slice. All operands and results use the active-high convention.

Top module: `fsel_alu_slice`

## Requirements
- R1: With `logic_mode_i`=1 and `carry_n_i`=1, each bit of `f_o` is a function of `a_i` and `b_i` at that position only. The function is chosen by `sel_i` as follows: 0000 ~A, 0001 ~(A|B), 0010 ~A&B, 0011 all zeros, 0100 ~(A&B), 0101 ~B, 0110 A^B, 0111 A&~B, 1000 ~A|B, 1001 ~(A^B), 1010 B, 1011 A&B, 1100 all ones, 1101 A|~B, 1110 A|B, 1111 A.
- R2: With `logic_mode_i`=1, `carry_n_i` has no effect on `f_o`. Driving it to 0 gives the same result as in R1.
- R3: With `logic_mode_i`=0 and `carry_n_i`=1, `f_o` = (X + Y) mod 16. Here X = A | (B & sel[0]) | (~B & sel[1]) and Y = (A & ~B & sel[2]) | (A & B & sel[3]), taken bitwise. Some codes give familiar results: 0000 passes A, 1001 gives A plus B, 0110 gives A minus B minus 1, 1100 gives A plus A, and 1111 gives A minus 1.
- R4: With `logic_mode_i`=0 and `carry_n_i`=0, `f_o` is one greater (mod 16) than the R3 result for the same inputs.
- R5: `carry_n_o` is 0 exactly when X + Y + (1 if `carry_n_i`=0) is 16 or more, in either mode. For code 0110 with `carry_n_i`=0, this means `carry_n_o`=0 when A ≥ B (no borrow) and 1 when A < B.
- R6: `eq_o` is 1 exactly when `f_o` is 1111. For arithmetic code 0110 with `carry_n_i`=1, `eq_o` is therefore 1 exactly when A equals B.
- R7: `prop_n_o` is 0 exactly when X = 1111. `gen_n_o` is 0 exactly when X + Y is 16 or more. Neither output depends on `carry_n_i`.
- R8: `carry_n_o` always equals `gen_n_o` AND (`prop_n_o` OR `carry_n_i`). A lookahead unit that combines the group terms therefore agrees with the ripple carry.
- R9: Four slices connected carry out to carry in form a 16-bit unit. That unit obeys R1 to R5 with 16-bit operands, where "16 or more" becomes "65536 or more".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | First operand, active high |
| b_i | input | 4 | Second operand, active high |
| sel_i | input | 4 | Function select code |
| logic_mode_i | input | 1 | 1 = per-bit logic functions, 0 = arithmetic functions |
| carry_n_i | input | 1 | Carry input, low-true (0 adds one) |
| f_o | output | 4 | Function result |
| carry_n_o | output | 1 | Ripple carry out, low-true |
| prop_n_o | output | 1 | Group propagate, low-true, independent of carry in |
| gen_n_o | output | 1 | Group generate, low-true, independent of carry in |
| eq_o | output | 1 | High when all result bits are 1 |

## Verification
The equality flag and the carry out answer the same comparison and can change in the same cycle. This happens under arithmetic code 0110 with equal operands. With the carry withheld, the result is all ones, `eq_o` rises and `carry_n_o` stays high. Applying the carry on the next vector turns the result to zero, drops `eq_o` and pulls `carry_n_o` low. The exhaustive operand sweep produces this pair in both carry states. In every cycle the scoreboard compares the flag and the carry, each against its own expected value, and separately checks the carry against the propagate and generate terms. The 16-bit chain is driven in the same cycles, so a carry that ripples across all four slices is judged together with the single-slice outputs.

// File: rtl/fsa_pkg.sv
// Package: shared constants for the function-select ALU slice.
// Names the select codes whose arithmetic meaning the checker relies on.
package fsa_pkg;

    typedef enum logic [3:0] {
        OP_PASS_A = 4'b0000,
        OP_SUB    = 4'b0110,
        OP_ADD    = 4'b1001,
        OP_DOUBLE = 4'b1100,
        OP_DEC    = 4'b1111
    } op_code_e;

    localparam int SEL_W = 4;

endpackage

// File: rtl/fsa_term_cell.sv
// Module: fsa_term_cell
// Forms, for every bit position, the two select-shaped terms that feed the
// adder: an OR-like term and an AND-like term. The AND-like term is always
// contained in the OR-like term, so the OR-like term doubles as the bit
// propagate and the AND-like term as the bit generate.
// Assumes: sel_i[0..1] shape the OR-like term, sel_i[2..3] the AND-like term.
module fsa_term_cell #(
    parameter int W = 4
) (
    input  logic [W-1:0]             a_i,
    input  logic [W-1:0]             b_i,
    input  logic [fsa_pkg::SEL_W-1:0] sel_i,
    output logic [W-1:0]             any_o,
    output logic [W-1:0]             both_o
);

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            // OR-like term: A, optionally widened by B or by NOT B.
            assign any_o[i]  = a_i[i] | (b_i[i] & sel_i[0]) | (~b_i[i] & sel_i[1]);
            // AND-like term: A, optionally masked by NOT B or by B.
            assign both_o[i] = (a_i[i] & ~b_i[i] & sel_i[2]) | (a_i[i] & b_i[i] & sel_i[3]);
        end
    endgenerate

endmodule

// File: rtl/fsa_carry_net.sv
// Module: fsa_carry_net
// Flat two-level carry lookahead across the slice. Every internal carry is
// written as a sum of products of bit generate/propagate terms and the carry
// input, so no carry waits on its neighbour. Also forms the group propagate
// and group generate, neither of which uses the carry input.
// Assumes: active-high carries inside; polarity handling is done by the top.
module fsa_carry_net #(
    parameter int W = 4
) (
    input  logic [W-1:0] prop_i,
    input  logic [W-1:0] gen_i,
    input  logic         cin_i,
    output logic [W:0]   carry_o,
    output logic         grp_prop_o,
    output logic         grp_gen_o
);

    // Expand each carry into its product terms.
    always_comb begin
        logic hit;
        logic term;
        carry_o    = '0;
        carry_o[0] = cin_i;
        for (int i = 0; i < W; i++) begin
            hit = cin_i;
            for (int k = 0; k <= i; k++) begin
                hit = hit & prop_i[k];
            end
            for (int j = 0; j <= i; j++) begin
                term = gen_i[j];
                for (int k = j + 1; k <= i; k++) begin
                    term = term & prop_i[k];
                end
                hit = hit | term;
            end
            carry_o[i+1] = hit;
        end
    end

    // Group generate: a carry leaves the slice with no carry entering it.
    always_comb begin
        logic term;
        grp_gen_o = 1'b0;
        for (int j = 0; j < W; j++) begin
            term = gen_i[j];
            for (int k = j + 1; k < W; k++) begin
                term = term & prop_i[k];
            end
            grp_gen_o = grp_gen_o | term;
        end
    end

    // Group propagate: every bit passes an incoming carry.
    assign grp_prop_o = &prop_i;

endmodule

// File: rtl/fsa_result_mux.sv
// Module: fsa_result_mux
// Chooses between the per-bit logic result and the arithmetic sum, and
// derives the all-ones flag from the chosen result.
// Assumes: in logic mode the carries count as forced high, which turns the
// half-sum into its complement and removes any dependence on the carry input.
module fsa_result_mux #(
    parameter int W = 4
) (
    input  logic [W-1:0] any_i,
    input  logic [W-1:0] both_i,
    input  logic [W-1:0] carry_i,
    input  logic         logic_mode_i,
    output logic [W-1:0] f_o,
    output logic         all_ones_o
);

    logic [W-1:0] half_sum;

    // Half sum shared by both modes.
    assign half_sum = any_i ^ both_i;

    // Logic mode ignores the carries; arithmetic mode folds them in.
    always_comb begin
        if (logic_mode_i) begin
            f_o = ~half_sum;
        end else begin
            f_o = half_sum ^ carry_i;
        end
    end

    // All-ones detector on the chosen result.
    assign all_ones_o = &f_o;

endmodule

// File: rtl/fsel_alu_slice.sv
// Module: fsel_alu_slice (top)
// Combinational function-select ALU slice. It takes two operands, a 4-bit
// select code and a mode bit, and produces a result, a low-true ripple carry,
// low-true group propagate/generate, and an all-ones equality flag.
// Assumes: active-high operands; every carry-related pin is low-true, so
// slices chain directly from carry_n_o to carry_n_i.
module fsel_alu_slice #(
    parameter int SLICE_W = 4
) (
    input  logic [SLICE_W-1:0]        a_i,
    input  logic [SLICE_W-1:0]        b_i,
    input  logic [fsa_pkg::SEL_W-1:0] sel_i,
    input  logic                      logic_mode_i,
    input  logic                      carry_n_i,
    output logic [SLICE_W-1:0]        f_o,
    output logic                      carry_n_o,
    output logic                      prop_n_o,
    output logic                      gen_n_o,
    output logic                      eq_o
);

    localparam int W = SLICE_W;

    logic [W-1:0] any_t;
    logic [W-1:0] both_t;
    logic [W:0]   carry_t;
    logic         grp_prop;
    logic         grp_gen;
    logic         cin_hi;

    // Convert the low-true carry input to the internal high-true form.
    assign cin_hi = ~carry_n_i;

    fsa_term_cell #(.W(W)) u_terms (
        .a_i    (a_i),
        .b_i    (b_i),
        .sel_i  (sel_i),
        .any_o  (any_t),
        .both_o (both_t)
    );

    fsa_carry_net #(.W(W)) u_carry (
        .prop_i     (any_t),
        .gen_i      (both_t),
        .cin_i      (cin_hi),
        .carry_o    (carry_t),
        .grp_prop_o (grp_prop),
        .grp_gen_o  (grp_gen)
    );

    fsa_result_mux #(.W(W)) u_mux (
        .any_i        (any_t),
        .both_i       (both_t),
        .carry_i      (carry_t[W-1:0]),
        .logic_mode_i (logic_mode_i),
        .f_o          (f_o),
        .all_ones_o   (eq_o)
    );

    // Drive the cascade pins in low-true form.
    assign carry_n_o = ~carry_t[W];
    assign prop_n_o  = ~grp_prop;
    assign gen_n_o   = ~grp_gen;

endmodule

// File: rtl/fsel_alu_slice_chk.sv
// Module: fsel_alu_slice_chk
// Assertion checker bound to every fsel_alu_slice instance. The slice has no
// clock, so the checks are immediate assertions re-evaluated whenever a port
// changes; each relates inputs to outputs or outputs to one another.
// Assumes: W >= 1.
module fsel_alu_slice_chk #(
    parameter int W = 4
) (
    input logic [W-1:0]              a_i,
    input logic [W-1:0]              b_i,
    input logic [fsa_pkg::SEL_W-1:0] sel_i,
    input logic                      logic_mode_i,
    input logic                      carry_n_i,
    input logic [W-1:0]              f_o,
    input logic                      carry_n_o,
    input logic                      prop_n_o,
    input logic                      gen_n_o,
    input logic                      eq_o
);

    logic [W:0] add_ref;
    logic [W:0] add_got;

    // Reference word sum for the plain-add code.
    always_comb begin
        add_ref = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, ~carry_n_i};
        add_got = {~carry_n_o, f_o};
    end

    // Port relations that must hold for every input combination.
    always_comb begin
        AST_LOGIC_XOR: assert (!(logic_mode_i && sel_i == fsa_pkg::OP_SUB) || (f_o == (a_i ^ b_i)))
            else $error("xor logic function wrong"); // R1
        AST_LOGIC_NO_CARRY: assert (!(logic_mode_i && sel_i == fsa_pkg::OP_DOUBLE) || (f_o == {W{1'b1}}))
            else $error("logic constant one wrong"); // R2
        AST_ADD_SUM: assert (!(!logic_mode_i && sel_i == fsa_pkg::OP_ADD) || (add_got == add_ref))
            else $error("add sum or carry wrong"); // R3
        AST_SUB_BORROW: assert (!(!logic_mode_i && sel_i == fsa_pkg::OP_SUB && !carry_n_i) || (carry_n_o == (a_i < b_i)))
            else $error("borrow sense wrong"); // R5
        AST_EQ_COMPARE: assert (!(!logic_mode_i && sel_i == fsa_pkg::OP_SUB && carry_n_i) || (eq_o == (a_i == b_i)))
            else $error("equality compare wrong"); // R6
        AST_GEN_FORCES_CARRY: assert (gen_n_o || !carry_n_o)
            else $error("generate without carry out"); // R7
        AST_CARRY_MATCHES_PG: assert (carry_n_o == (gen_n_o & (prop_n_o | carry_n_i)))
            else $error("ripple carry disagrees with group terms"); // R8
    end

endmodule

bind fsel_alu_slice fsel_alu_slice_chk #(.W(SLICE_W)) u_chk (
    .a_i          (a_i),
    .b_i          (b_i),
    .sel_i        (sel_i),
    .logic_mode_i (logic_mode_i),
    .carry_n_i    (carry_n_i),
    .f_o          (f_o),
    .carry_n_o    (carry_n_o),
    .prop_n_o     (prop_n_o),
    .gen_n_o      (gen_n_o),
    .eq_o         (eq_o)
);

// File: tb/fsel_alu_slice_tb.sv
// Scoreboard bench: the driver applies a vector just after a rising edge and
// queues the expected outputs computed from the requirement tables; the
// monitor pops one item at each falling edge and compares it with the single
// slice (u_dut) and with a 16-bit chain of four slices.
module fsel_alu_slice_tb;

    localparam int W  = 4;
    localparam int NS = 4;
    localparam int CW = W * NS;

    logic clk = 1'b0;
    always #4 clk = ~clk;  // 125 MHz
    logic rst_n;

    logic [W-1:0]  a, b;
    logic [3:0]    sel;
    logic          md, cn;
    logic [CW-1:0] a16, b16;

    wire [W-1:0]  f;
    wire          co_n, p_n, g_n, eq;
    wire [CW-1:0] f16;
    wire [NS:0]   cc;
    wire [NS-1:0] ch_p, ch_g, ch_eq;

    fsel_alu_slice #(.SLICE_W(W)) u_dut (
        .a_i(a), .b_i(b), .sel_i(sel), .logic_mode_i(md), .carry_n_i(cn),
        .f_o(f), .carry_n_o(co_n), .prop_n_o(p_n), .gen_n_o(g_n), .eq_o(eq)
    );

    assign cc[0] = cn;
    generate
        for (genvar k = 0; k < NS; k++) begin : g_chain
            fsel_alu_slice #(.SLICE_W(W)) u_chain (
                .a_i(a16[k*W +: W]), .b_i(b16[k*W +: W]), .sel_i(sel),
                .logic_mode_i(md), .carry_n_i(cc[k]),
                .f_o(f16[k*W +: W]), .carry_n_o(cc[k+1]),
                .prop_n_o(ch_p[k]), .gen_n_o(ch_g[k]), .eq_o(ch_eq[k])
            );
        end
    endgenerate

    typedef struct {
        logic [CW-1:0] f;
        logic          co;
        logic          p;
        logic          g;
    } exp_t;

    typedef struct {
        logic   md;
        logic   cn;
        logic [3:0] sel;
        logic [W-1:0] a;
        logic [W-1:0] b;
        exp_t   e4;
        exp_t   e16;
    } item_t;

    item_t q[$];
    item_t it;
    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    logic [31:0] rs = 32'h1ACE_B00C;

    // Expected outputs from the requirement tables for a w-bit word.
    function automatic exp_t model(input logic [CW-1:0] ta, input logic [CW-1:0] tb,
                                   input logic [3:0] s, input logic tm, input logic tc,
                                   input int w);
        logic [CW:0]   mask, raw, sum;
        logic [CW-1:0] ones, x, y, lg;
        exp_t r;
        mask = ({{CW{1'b0}}, 1'b1} << w) - 1'b1;
        ones = mask[CW-1:0];
        case (s)
            4'b0000: begin x = ta;        y = '0;        lg = ~ta;        end
            4'b0001: begin x = ta | tb;   y = '0;        lg = ~(ta | tb); end
            4'b0010: begin x = ta | ~tb;  y = '0;        lg = ~ta & tb;   end
            4'b0011: begin x = ones;      y = '0;        lg = '0;         end
            4'b0100: begin x = ta;        y = ta & ~tb;  lg = ~(ta & tb); end
            4'b0101: begin x = ta | tb;   y = ta & ~tb;  lg = ~tb;        end
            4'b0110: begin x = ta | ~tb;  y = ta & ~tb;  lg = ta ^ tb;    end
            4'b0111: begin x = ones;      y = ta & ~tb;  lg = ta & ~tb;   end
            4'b1000: begin x = ta;        y = ta & tb;   lg = ~ta | tb;   end
            4'b1001: begin x = ta | tb;   y = ta & tb;   lg = ~(ta ^ tb); end
            4'b1010: begin x = ta | ~tb;  y = ta & tb;   lg = tb;         end
            4'b1011: begin x = ones;      y = ta & tb;   lg = ta & tb;    end
            4'b1100: begin x = ta;        y = ta;        lg = ones;       end
            4'b1101: begin x = ta | tb;   y = ta;        lg = ta | ~tb;   end
            4'b1110: begin x = ta | ~tb;  y = ta;        lg = ta | tb;    end
            default: begin x = ones;      y = ta;        lg = ta;         end
        endcase
        x    = x & ones;
        y    = y & ones;
        raw  = {1'b0, x} + {1'b0, y};
        sum  = raw + {{CW{1'b0}}, ~tc};
        r.p  = (x == ones);
        r.g  = (raw > mask);
        r.co = (sum > mask);
        r.f  = tm ? (lg & ones) : (sum[CW-1:0] & ones);
        return r;
    endfunction

    // Record one comparison; report a mismatch on a single line.
    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one vector and queue its expected outputs.
    task automatic drive(input logic [W-1:0] ta, input logic [W-1:0] tb,
                         input logic [3:0] ts, input logic tm, input logic tc,
                         input logic [CW-1:0] wa, input logic [CW-1:0] wb);
        item_t n;
        @(posedge clk);
        #1;
        a = ta; b = tb; sel = ts; md = tm; cn = tc; a16 = wa; b16 = wb;
        n.md  = tm; n.cn = tc; n.sel = ts; n.a = ta; n.b = tb;
        n.e4  = model({{(CW-W){1'b0}}, ta}, {{(CW-W){1'b0}}, tb}, ts, tm, tc, W);
        n.e16 = model(wa, wb, ts, tm, tc, CW);
        q.push_back(n);
    endtask

    // Monitor: compare the design against the oldest queued item.
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            string ftag;
            it = q.pop_front();
            if (it.md) ftag = it.cn ? "R1" : "R2";
            else       ftag = it.cn ? "R3" : "R4";
            check(f == it.e4.f[W-1:0], ftag, $sformatf("result sel=%b a=%h b=%h", it.sel, it.a, it.b),
                  32'(f), 32'(it.e4.f[W-1:0]));
            check(co_n == !it.e4.co, "R5", $sformatf("carry_n_o sel=%b md=%b", it.sel, it.md),
                  32'(co_n), 32'(!it.e4.co));
            check(eq == (it.e4.f[W-1:0] == {W{1'b1}}), "R6", "eq_o",
                  32'(eq), 32'(it.e4.f[W-1:0] == {W{1'b1}}));
            check(p_n == !it.e4.p, "R7", "prop_n_o", 32'(p_n), 32'(!it.e4.p));
            check(g_n == !it.e4.g, "R7", "gen_n_o", 32'(g_n), 32'(!it.e4.g));
            check(co_n == (g_n & (p_n | it.cn)), "R8", "carry vs group terms",
                  32'(co_n), 32'(g_n & (p_n | it.cn)));
            check({!cc[NS], f16} == {it.e16.co, it.e16.f}, "R9",
                  $sformatf("16-bit chain sel=%b md=%b", it.sel, it.md),
                  32'({!cc[NS], f16}), 32'({it.e16.co, it.e16.f}));
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R9 actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        rst_n = 1'b0;
        a = '0; b = '0; sel = '0; md = 1'b0; cn = 1'b1; a16 = '0; b16 = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state after reset: zero operands, pass-A, no carry (R3).
        drive('0, '0, 4'b0000, 1'b0, 1'b1, '0, '0);
        // Directed: equal operands under subtract, carry withheld then applied (R6, R5).
        drive(4'h9, 4'h9, 4'b0110, 1'b0, 1'b1, 16'h1234, 16'h1234);
        drive(4'h9, 4'h9, 4'b0110, 1'b0, 1'b0, 16'h1234, 16'h1234);
        drive(4'h3, 4'h4, 4'b0110, 1'b0, 1'b0, 16'h1234, 16'h1235);
        // Directed: carry rippling through all four slices (R9).
        drive(4'hF, 4'h1, 4'b1001, 1'b0, 1'b1, 16'hFFFF, 16'h0001);
        drive(4'hF, 4'h0, 4'b0000, 1'b0, 1'b0, 16'hFFFF, 16'h0000);
        drive(4'h0, 4'h0, 4'b1111, 1'b0, 1'b1, 16'h0000, 16'h0000);
        // Logic mode with carry toggled, result must not move (R2).
        drive(4'hA, 4'h6, 4'b0110, 1'b1, 1'b1, 16'hA5A5, 16'h0FF0);
        drive(4'hA, 4'h6, 4'b0110, 1'b1, 1'b0, 16'hA5A5, 16'h0FF0);
        // Exhaustive sweep over mode, carry, code and operands (R1..R9).
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 2; c++) begin
                for (int s = 0; s < 16; s++) begin
                    for (int ai = 0; ai < 16; ai++) begin
                        for (int bi = 0; bi < 16; bi++) begin
                            logic [CW-1:0] wa, wb;
                            rs = rs ^ (rs << 13);
                            rs = rs ^ (rs >> 17);
                            rs = rs ^ (rs << 5);
                            wa = rs[15:0];
                            wb = rs[31:16];
                            drive(W'(ai), W'(bi), 4'(s), m[0], c[0], wa, wb);
                        end
                    end
                end
            end
        end
        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule